// File: doc/BRIEF.md
# Tunnel Decapsulation Admission Checker

This block decides, one tunnelled packet at a time, whether a received packet may be decapsulated under a single programmed decapsulation entry or must be handed to the CPU. The entry is loaded through a configuration port. It holds:

- a source-check mode;
- a three-bit mask of permitted encapsulation kinds;
- a key-check enable;
- the expected IPv4 underlay source;
- the expected IPv6 source-table index;
- the expected GRE key;
- the overlay router interface index that passing packets inherit.

A parser upstream supplies a descriptor for each packet. The descriptor carries the underlay version, the IPv4 source, the result of the IPv6 source-table lookup, the encapsulation kind and the GRE key. The block registers a verdict one cycle after it accepts a descriptor. The verdict travels with a trap code, the interface index and a three-bit bitmap of which checks failed.

Descriptors and verdicts both use valid/ready handshakes. One descriptor can be accepted every cycle. The output register holds its verdict while the consumer stalls. A configuration write lands on a clock edge, and every descriptor is judged against the configuration that was in place when it was accepted.

Top module: `tun_decap_admit`

## Requirements
- R1: Source mode 0 performs no source check. Bit 0 of the failure bitmap stays clear whatever underlay version or address the packet carries.
- R2: Source mode 1 sets failure bit 0 when the underlay is IPv6 or when the IPv4 source differs from the programmed IPv4 address.
- R3: Source mode 3 sets failure bit 0 in any of three cases: the underlay is IPv4, the IPv6 lookup missed, or the looked-up index differs from the programmed index.
- R4: Source mode 2 is reserved, and every packet fails the source check under it.
- R5: Mask bit k permits encapsulation kind k, where kind 0 is plain IP-in-IP, kind 1 is GRE without key and kind 2 is GRE with key. A kind that is not permitted, or the reserved kind 3, sets failure bit 1.
- R6: With key checking enabled, kind 0 always passes the key check and kinds 1 and 3 always fail it. Kind 2 passes only when the packet key equals the 32-bit expected key. A key failure sets failure bit 2.
- R7: With key checking disabled, the packet key and the expected key have no effect, and failure bit 2 stays clear.
- R8: A packet passes only when all three failure bits are clear. A passing packet has trap code 0 and carries the programmed interface index. A failing packet has trap code 0xB1 and interface index 0.
- R9: A descriptor accepted on an edge produces its verdict on that same edge. `in_ready_o` is high exactly when the output register is empty or is being drained. While the consumer stalls, the verdict stays stable.
- R10: A configuration write on the same edge as a descriptor acceptance affects only descriptors accepted later.
- R11: Reset empties the output register and sets mode 0, empty mask, key check off, and zero addresses, key and index. A packet that arrives after reset is therefore trapped with failure bitmap 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the configuration fields below |
| cfg_src_mode_i | input | 2 | Source-check mode (0 none, 1 IPv4, 2 reserved, 3 IPv6) |
| cfg_type_mask_i | input | 3 | Permitted encapsulation kinds, one bit per kind |
| cfg_key_chk_i | input | 1 | Enable the GRE key check |
| cfg_v4_addr_i | input | ADDR_W | Expected IPv4 underlay source |
| cfg_v6_idx_i | input | IDX_W | Expected IPv6 source-table index |
| cfg_key_i | input | KEY_W | Expected GRE key |
| cfg_rif_i | input | RIF_W | Overlay interface index for passing packets |
| in_valid_i | input | 1 | Descriptor valid |
| in_ready_o | output | 1 | Descriptor accepted when high with valid |
| in_is_v6_i | input | 1 | Underlay is IPv6 |
| in_v4_addr_i | input | ADDR_W | IPv4 underlay source |
| in_v6_hit_i | input | 1 | IPv6 source found in the table |
| in_v6_idx_i | input | IDX_W | Table index of the IPv6 source |
| in_kind_i | input | 2 | Encapsulation kind (0 IP-in-IP, 1 GRE, 2 GRE with key, 3 reserved) |
| in_key_i | input | KEY_W | GRE key from the packet |
| out_valid_o | output | 1 | Verdict valid |
| out_ready_i | input | 1 | Consumer takes the verdict |
| out_pass_o | output | 1 | Packet may be decapsulated |
| out_trap_code_o | output | 8 | 0 on pass, 0xB1 on trap |
| out_rif_o | output | RIF_W | Overlay interface index on pass, 0 on trap |
| out_fail_o | output | 3 | Failure bitmap: bit 0 source, bit 1 type, bit 2 key |

## Verification
The bench targets the asymmetric key rules:

- Plain IP-in-IP must survive an enabled key check. A design that compares keys for every kind would trap it.
- Keyless GRE must fail an enabled key check. A design that compares keys for every kind would let it through.
- A mismatched key must pass while checking is off. A design that ignores the enable would trap it.

It also covers the source-mode corners:

- An IPv6 underlay presented in IPv4 mode.
- An IPv4 underlay presented in IPv6 mode.
- A lookup miss whose stale index happens to match.
- The reserved mode.

A design that skipped the version test, or trusted the index without its hit flag, would pass these wrongly.

Three timing cases check when configuration and results take effect:

- A configuration write on the edge of an acceptance. A design that bypassed the write would judge that packet with the new mask.
- A stall that exercises the handshake. A design that overwrote its output register during the stall would lose the held verdict.
- A packet sent straight after reset, which must be trapped under the empty mask.

// File: rtl/tun_decap_pkg.sv
package tun_decap_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_V4   = 2'd1,
    SRC_RSV  = 2'd2,
    SRC_V6   = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    ENC_IPIP    = 2'd0,
    ENC_GRE     = 2'd1,
    ENC_GRE_KEY = 2'd2,
    ENC_RSV     = 2'd3
  } enc_kind_e;

  localparam int NUM_KIND  = 3;
  localparam int NUM_CHK   = 3;
  localparam int FAIL_SRC  = 0;
  localparam int FAIL_TYPE = 1;
  localparam int FAIL_KEY  = 2;
  localparam int TRAP_W    = 8;
  localparam logic [TRAP_W-1:0] TRAP_DECAP_ERR = 8'hB1;
endpackage

// File: rtl/tun_decap_cfg.sv
module tun_decap_cfg
  import tun_decap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int KEY_W  = 32,
  parameter int RIF_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          src_mode_i,
  input  logic [NUM_KIND-1:0] type_mask_i,
  input  logic                key_chk_i,
  input  logic [ADDR_W-1:0]   v4_addr_i,
  input  logic [IDX_W-1:0]    v6_idx_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic [RIF_W-1:0]    rif_i,
  output src_mode_e           src_mode_o,
  output logic [NUM_KIND-1:0] type_mask_o,
  output logic                key_chk_o,
  output logic [ADDR_W-1:0]   v4_addr_o,
  output logic [IDX_W-1:0]    v6_idx_o,
  output logic [KEY_W-1:0]    key_o,
  output logic [RIF_W-1:0]    rif_o
);
  // Write lands on the edge; same-edge accepts still see the old value.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_mode_o  <= SRC_NONE;
      type_mask_o <= '0;
      key_chk_o   <= 1'b0;
      v4_addr_o   <= '0;
      v6_idx_o    <= '0;
      key_o       <= '0;
      rif_o       <= '0;
    end else if (we_i) begin
      src_mode_o  <= src_mode_e'(src_mode_i);
      type_mask_o <= type_mask_i;
      key_chk_o   <= key_chk_i;
      v4_addr_o   <= v4_addr_i;
      v6_idx_o    <= v6_idx_i;
      key_o       <= key_i;
      rif_o       <= rif_i;
    end
  end
endmodule

// File: rtl/tun_decap_chk.sv
module tun_decap_chk
  import tun_decap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int KEY_W  = 32
) (
  input  src_mode_e           mode_i,
  input  logic [NUM_KIND-1:0] mask_i,
  input  logic                key_chk_i,
  input  logic [ADDR_W-1:0]   exp_v4_i,
  input  logic [IDX_W-1:0]    exp_idx_i,
  input  logic [KEY_W-1:0]    exp_key_i,
  input  logic                is_v6_i,
  input  logic [ADDR_W-1:0]   v4_addr_i,
  input  logic                v6_hit_i,
  input  logic [IDX_W-1:0]    v6_idx_i,
  input  logic [1:0]          kind_i,
  input  logic [KEY_W-1:0]    key_i,
  output logic [NUM_CHK-1:0]  fail_o
);
  logic                src_fail;
  logic                key_fail;
  logic [NUM_KIND-1:0] kind_hot;

  always_comb begin
    unique case (mode_i)
      SRC_NONE: src_fail = 1'b0;
      SRC_V4:   src_fail = is_v6_i || (v4_addr_i != exp_v4_i);
      SRC_V6:   src_fail = !is_v6_i || !v6_hit_i || (v6_idx_i != exp_idx_i);
      default:  src_fail = 1'b1;
    endcase
  end

  // Kind decode; reserved kind lights no bit and so is never permitted.
  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    assign kind_hot[k] = (kind_i == k[1:0]);
  end

  always_comb begin
    key_fail = 1'b0;
    if (key_chk_i) begin
      unique case (enc_kind_e'(kind_i))
        ENC_IPIP:    key_fail = 1'b0;
        ENC_GRE_KEY: key_fail = (key_i != exp_key_i);
        default:     key_fail = 1'b1;
      endcase
    end
  end

  assign fail_o[FAIL_SRC]  = src_fail;
  assign fail_o[FAIL_TYPE] = ~|(kind_hot & mask_i);
  assign fail_o[FAIL_KEY]  = key_fail;
endmodule

// File: rtl/tun_decap_out.sv
module tun_decap_out
  import tun_decap_pkg::*;
#(
  parameter int RIF_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [NUM_CHK-1:0] fail_i,
  input  logic [RIF_W-1:0]   rif_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               out_pass_o,
  output logic [TRAP_W-1:0]  out_trap_code_o,
  output logic [RIF_W-1:0]   out_rif_o,
  output logic [NUM_CHK-1:0] out_fail_o
);
  logic pass_d;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign pass_d     = (fail_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o     <= 1'b0;
      out_pass_o      <= 1'b0;
      out_trap_code_o <= '0;
      out_rif_o       <= '0;
      out_fail_o      <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_pass_o      <= pass_d;
        out_trap_code_o <= pass_d ? '0 : TRAP_DECAP_ERR;
        out_rif_o       <= pass_d ? rif_i : '0;
        out_fail_o      <= fail_i;
      end
    end
  end
endmodule

// File: rtl/tun_decap_admit.sv
module tun_decap_admit
  import tun_decap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int KEY_W  = 32,
  parameter int RIF_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_src_mode_i,
  input  logic [2:0]          cfg_type_mask_i,
  input  logic                cfg_key_chk_i,
  input  logic [ADDR_W-1:0]   cfg_v4_addr_i,
  input  logic [IDX_W-1:0]    cfg_v6_idx_i,
  input  logic [KEY_W-1:0]    cfg_key_i,
  input  logic [RIF_W-1:0]    cfg_rif_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                in_is_v6_i,
  input  logic [ADDR_W-1:0]   in_v4_addr_i,
  input  logic                in_v6_hit_i,
  input  logic [IDX_W-1:0]    in_v6_idx_i,
  input  logic [1:0]          in_kind_i,
  input  logic [KEY_W-1:0]    in_key_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                out_pass_o,
  output logic [7:0]          out_trap_code_o,
  output logic [RIF_W-1:0]    out_rif_o,
  output logic [2:0]          out_fail_o
);
  src_mode_e           act_mode;
  logic [NUM_KIND-1:0] act_mask;
  logic                act_key_chk;
  logic [ADDR_W-1:0]   act_v4;
  logic [IDX_W-1:0]    act_idx;
  logic [KEY_W-1:0]    act_key;
  logic [RIF_W-1:0]    act_rif;
  logic [NUM_CHK-1:0]  fail_d;

  tun_decap_cfg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KEY_W(KEY_W), .RIF_W(RIF_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .src_mode_i  (cfg_src_mode_i),
    .type_mask_i (cfg_type_mask_i),
    .key_chk_i   (cfg_key_chk_i),
    .v4_addr_i   (cfg_v4_addr_i),
    .v6_idx_i    (cfg_v6_idx_i),
    .key_i       (cfg_key_i),
    .rif_i       (cfg_rif_i),
    .src_mode_o  (act_mode),
    .type_mask_o (act_mask),
    .key_chk_o   (act_key_chk),
    .v4_addr_o   (act_v4),
    .v6_idx_o    (act_idx),
    .key_o       (act_key),
    .rif_o       (act_rif)
  );

  tun_decap_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KEY_W(KEY_W)) i_chk (
    .mode_i    (act_mode),
    .mask_i    (act_mask),
    .key_chk_i (act_key_chk),
    .exp_v4_i  (act_v4),
    .exp_idx_i (act_idx),
    .exp_key_i (act_key),
    .is_v6_i   (in_is_v6_i),
    .v4_addr_i (in_v4_addr_i),
    .v6_hit_i  (in_v6_hit_i),
    .v6_idx_i  (in_v6_idx_i),
    .kind_i    (in_kind_i),
    .key_i     (in_key_i),
    .fail_o    (fail_d)
  );

  tun_decap_out #(.RIF_W(RIF_W)) i_out (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .in_valid_i      (in_valid_i),
    .in_ready_o      (in_ready_o),
    .fail_i          (fail_d),
    .rif_i           (act_rif),
    .out_valid_o     (out_valid_o),
    .out_ready_i     (out_ready_i),
    .out_pass_o      (out_pass_o),
    .out_trap_code_o (out_trap_code_o),
    .out_rif_o       (out_rif_o),
    .out_fail_o      (out_fail_o)
  );
endmodule

// File: rtl/tun_decap_admit_chk.sv
module tun_decap_admit_chk
  import tun_decap_pkg::*;
#(
  parameter int RIF_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_ready_i,
  input logic                out_valid_o,
  input logic                out_pass_o,
  input logic [7:0]          out_trap_code_o,
  input logic [RIF_W-1:0]    out_rif_o,
  input logic [2:0]          out_fail_o,
  input src_mode_e           act_mode,
  input logic [NUM_KIND-1:0] act_mask,
  input logic                act_key_chk
);
  // R9
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pass_o) &&
      $stable(out_fail_o) && $stable(out_rif_o) && $stable(out_trap_code_o));

  // R9
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R9
  ready_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o || out_ready_i) |-> in_ready_o);

  // R8
  trap_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_pass_o |-> out_trap_code_o == TRAP_DECAP_ERR && out_rif_o == '0 &&
      out_fail_o != '0);

  // R8
  pass_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_pass_o |-> out_trap_code_o == '0 && out_fail_o == '0);

  // R7
  key_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !act_key_chk |=> !out_fail_o[FAIL_KEY]);

  // R1
  src_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && act_mode == SRC_NONE |=> !out_fail_o[FAIL_SRC]);

  // R5
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && act_mask == '0 |=> out_fail_o[FAIL_TYPE]);
endmodule

bind tun_decap_admit tun_decap_admit_chk #(.RIF_W(RIF_W)) i_admit_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_valid_i      (in_valid_i),
  .in_ready_o      (in_ready_o),
  .out_ready_i     (out_ready_i),
  .out_valid_o     (out_valid_o),
  .out_pass_o      (out_pass_o),
  .out_trap_code_o (out_trap_code_o),
  .out_rif_o       (out_rif_o),
  .out_fail_o      (out_fail_o),
  .act_mode        (act_mode),
  .act_mask        (act_mask),
  .act_key_chk     (act_key_chk)
);

// File: tb/test_tun_decap_admit.sv
module test_tun_decap_admit;
  localparam logic [31:0] V4A = 32'h0A00_0001;
  localparam logic [31:0] V4B = 32'h0A00_0002;
  localparam logic [31:0] KA  = 32'h0000_1234;
  localparam logic [31:0] KB  = 32'h0000_1235;
  localparam logic [11:0] I5  = 12'd5;
  localparam logic [11:0] I6  = 12'd6;
  localparam logic [15:0] RIF = 16'h0042;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  mask;
    logic        kchk;
    logic        v6;
    logic        hit;
    logic [11:0] pidx;
    logic [31:0] saddr;
    logic [1:0]  kind;
    logic [31:0] pkey;
    logic [2:0]  efail;
  } vec_t;

  localparam int NV = 18;
  // efail bits: [2] key, [1] type, [0] source
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd7, 1'b0, 1'b0, 1'b0, I6, V4B, 2'd0, KB, 3'b000}, // R1
    '{2'd1, 3'd7, 1'b0, 1'b0, 1'b0, I5, V4A, 2'd1, KA, 3'b000}, // R2
    '{2'd1, 3'd7, 1'b0, 1'b0, 1'b0, I5, V4B, 2'd1, KA, 3'b001}, // R2
    '{2'd1, 3'd7, 1'b0, 1'b1, 1'b1, I5, V4A, 2'd1, KA, 3'b001}, // R2
    '{2'd3, 3'd7, 1'b0, 1'b1, 1'b1, I5, V4B, 2'd0, KA, 3'b000}, // R3
    '{2'd3, 3'd7, 1'b0, 1'b1, 1'b1, I6, V4A, 2'd0, KA, 3'b001}, // R3
    '{2'd3, 3'd7, 1'b0, 1'b0, 1'b1, I5, V4A, 2'd0, KA, 3'b001}, // R3
    '{2'd3, 3'd7, 1'b0, 1'b1, 1'b0, I5, V4A, 2'd0, KA, 3'b001}, // R3
    '{2'd2, 3'd7, 1'b0, 1'b0, 1'b0, I5, V4A, 2'd0, KA, 3'b001}, // R4
    '{2'd0, 3'd1, 1'b0, 1'b0, 1'b0, I5, V4A, 2'd1, KA, 3'b010}, // R5
    '{2'd0, 3'd6, 1'b0, 1'b0, 1'b0, I5, V4A, 2'd0, KA, 3'b010}, // R5
    '{2'd0, 3'd7, 1'b1, 1'b0, 1'b0, I5, V4A, 2'd0, KB, 3'b000}, // R6
    '{2'd0, 3'd7, 1'b1, 1'b0, 1'b0, I5, V4A, 2'd1, KA, 3'b100}, // R6
    '{2'd0, 3'd7, 1'b1, 1'b0, 1'b0, I5, V4A, 2'd2, KA, 3'b000}, // R6
    '{2'd0, 3'd7, 1'b1, 1'b0, 1'b0, I5, V4A, 2'd2, KB, 3'b100}, // R6
    '{2'd0, 3'd7, 1'b0, 1'b0, 1'b0, I5, V4A, 2'd2, KB, 3'b000}, // R7
    '{2'd0, 3'd7, 1'b1, 1'b0, 1'b0, I5, V4A, 2'd3, KA, 3'b110}, // R5 R6
    '{2'd1, 3'd4, 1'b1, 1'b0, 1'b0, I5, V4B, 2'd1, KA, 3'b111}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [2:0]  cfg_mask = '0;
  logic        cfg_kchk = 1'b0;
  logic [31:0] cfg_v4 = '0;
  logic [11:0] cfg_idx = '0;
  logic [31:0] cfg_key = '0;
  logic [15:0] cfg_rif = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_v6 = 1'b0;
  logic [31:0] in_v4 = '0;
  logic        in_hit = 1'b0;
  logic [11:0] in_idx = '0;
  logic [1:0]  in_kind = '0;
  logic [31:0] in_key = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_pass;
  logic [7:0]  out_trap;
  logic [15:0] out_rif;
  logic [2:0]  out_fail;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tun_decap_admit i_tun_decap_admit (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_src_mode_i(cfg_mode), .cfg_type_mask_i(cfg_mask),
    .cfg_key_chk_i(cfg_kchk), .cfg_v4_addr_i(cfg_v4), .cfg_v6_idx_i(cfg_idx),
    .cfg_key_i(cfg_key), .cfg_rif_i(cfg_rif),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_is_v6_i(in_v6),
    .in_v4_addr_i(in_v4), .in_v6_hit_i(in_hit), .in_v6_idx_i(in_idx),
    .in_kind_i(in_kind), .in_key_i(in_key),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pass_o(out_pass),
    .out_trap_code_o(out_trap), .out_rif_o(out_rif), .out_fail_o(out_fail)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare the full verdict against the expected failure bitmap.
  task automatic check_verdict(input string req, input logic [2:0] efail);
    logic ep;
    ep = (efail == 3'b000);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " fail"}, 64'(out_fail), 64'(efail));
    check({req, " pass"}, 64'(out_pass), 64'(ep));
    check({req, " trap"}, 64'(out_trap), ep ? 64'd0 : 64'hB1);
    check({req, " rif"}, 64'(out_rif), ep ? 64'(RIF) : 64'd0);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [2:0] k, input logic kc);
    cfg_mode = m; cfg_mask = k; cfg_kchk = kc;
    cfg_v4 = V4A; cfg_idx = I5; cfg_key = KA; cfg_rif = RIF;
  endtask

  task automatic set_pkt(input vec_t v);
    in_v6 = v.v6; in_hit = v.hit; in_idx = v.pidx; in_v4 = v.saddr;
    in_kind = v.kind; in_key = v.pkey;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", 64'(out_valid), 64'd0);
    check("R11 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after release", 64'(out_valid), 64'd0);
    // R11 packet with reset configuration: nothing permitted
    v = VECS[1];
    set_pkt(v); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_verdict("R11", 3'b010);

    // Table walk: program, then one packet
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      @(negedge clk);
      set_cfg(v.mode, v.mask, v.kchk); cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      set_pkt(v); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_verdict($sformatf("R8 vec%0d", i), v.efail);
    end

    // R10 write on the acceptance edge: old mask 7 judges this packet
    @(negedge clk);
    set_cfg(2'd0, 3'd7, 1'b0); cfg_we = 1'b1;
    @(negedge clk);
    set_cfg(2'd0, 3'd0, 1'b0); cfg_we = 1'b1;
    v = VECS[0];
    set_pkt(v); in_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check_verdict("R10 old cfg", 3'b000);
    @(negedge clk);
    in_valid = 1'b0;
    check_verdict("R10 new cfg", 3'b010);

    // R9 back-to-back and stall
    @(negedge clk);
    set_cfg(2'd1, 3'd7, 1'b0); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    out_ready = 1'b0;
    v = VECS[1]; set_pkt(v); in_valid = 1'b1;          // passes
    @(negedge clk);
    v = VECS[2]; set_pkt(v);                           // source fail
    check("R9 ready low in stall", 64'(in_ready), 64'd0);
    check_verdict("R9 first", 3'b000);
    @(negedge clk);
    check_verdict("R9 held", 3'b000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_verdict("R9 second", 3'b001);
    @(negedge clk);
    check("R9 drained", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule